// File: doc/BRIEF.md
# Complex Down-Converter with Two-Stage Decimating Filter

This block takes a stream of signed fixed-point complex samples and shifts it in frequency by multiplying each sample with a rotating unit phasor. A phase accumulator advances by a programmable step for each accepted sample. Its top six bits index a 64-point sine table, which is built from a 17-entry quarter wave by symmetry folding. The rotated stream goes through a first FIR filter, which uses one coefficient set for both the real and imaginary lanes. The filter output is thinned to one sample in every `DECIM`, and the kept samples go through a second FIR filter with its own coefficient set.

Samples arrive in buffers, and the first sample of each buffer is flagged. That flag restarts the phase at zero and empties both filters, so that samples from before the buffer count as zero. It also restarts the decimation count. Every operator has a fixed latency, and stages are aligned by registers only. The only flow control is one global advance signal: the whole chain moves when the output is free or taken. Coefficients are written one tap at a time through a small write port.

Top module: `iq_ddc`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The rotated sample is re' = re·cos θ − im·sin θ and im' = im·cos θ + re·sin θ. Here θ = 2π·p/64, and p is the top six bits of the 16-bit phase. The cos and sin values are Q1.15 with a peak of 32767.
- R3: The first sample of a buffer (`in_first` = 1) uses phase 0. Each later accepted sample uses the previous phase plus `freq_word`, modulo 2^16.
- R4: Both lanes of the first filter produce y[t] = Σ a[k]·x[t−k] for k = 0..NT1−1. The coefficients are signed Q1.15 and the same set is used for both lanes. The sum is rounded to nearest by a right shift of 15.
- R5: Samples from before the first sample of a buffer contribute zero to both filters.
- R6: Within a buffer, only first-filter outputs 0, DECIM, 2·DECIM, … are kept. The count restarts at each buffer start.
- R7: The kept samples pass through a second filter of the same form as R4, using coefficient bank 1.
- R8: Every arithmetic result saturates to the signed 16-bit range [−32768, 32767].
- R9: When the output is not stalled, a sample accepted at a rising edge and kept by the decimator appears on `out_valid` at the third rising edge after that edge.
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the output values hold. No sample is lost or duplicated.
- R11: A write with `coef_we` = 1 stores `coef_val` into tap `coef_idx` of bank `coef_bank`. Bank 0 feeds the first filter and bank 1 feeds the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | PW | Phase step per accepted sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_bank | input | 1 | 0 = first filter, 1 = second filter |
| coef_idx | input | IW | Tap index |
| coef_val | input | CW | Signed Q1.15 coefficient |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Chain can accept a sample |
| in_first | input | 1 | Marks the first sample of a buffer |
| in_re | input | DW | Input real part |
| in_im | input | DW | Input imaginary part |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output |
| out_first | output | 1 | Output is the first kept sample of a buffer |
| out_re | output | DW | Output real part |
| out_im | output | DW | Output imaginary part |

## Verification
The assertions assume that `in_first` comes with the first accepted sample of every buffer. They also assume that `freq_word` and both coefficient banks hold steady while a buffer is in flight. The bench writes coefficients and changes the phase step only while the chain is empty and fully drained. It flags the first sample of every buffer it sends. The hold properties assume a consumer that may drop `out_ready` at any cycle, and the bench drives exactly that with a pseudo-random ready pattern.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  localparam int TW    = 16;
  localparam int TFRAC = 15;

  function automatic logic signed [TW-1:0] qtab(input logic [4:0] k);
    case (k)
      5'd0:  return 16'sd0;
      5'd1:  return 16'sd3212;
      5'd2:  return 16'sd6393;
      5'd3:  return 16'sd9512;
      5'd4:  return 16'sd12539;
      5'd5:  return 16'sd15446;
      5'd6:  return 16'sd18204;
      5'd7:  return 16'sd20787;
      5'd8:  return 16'sd23170;
      5'd9:  return 16'sd25329;
      5'd10: return 16'sd27245;
      5'd11: return 16'sd28898;
      5'd12: return 16'sd30273;
      5'd13: return 16'sd31356;
      5'd14: return 16'sd32137;
      5'd15: return 16'sd32609;
      default: return 16'sd32767;
    endcase
  endfunction

  function automatic logic signed [TW-1:0] qsin(input logic [5:0] p);
    logic signed [TW-1:0] mag;
    mag = p[4] ? qtab(5'd16 - {1'b0, p[3:0]}) : qtab({1'b0, p[3:0]});
    return p[5] ? -mag : mag;
  endfunction

  function automatic logic signed [63:0] rnd_sat(input logic signed [63:0] v,
                                                 input int unsigned sh,
                                                 input int unsigned ow);
    logic signed [63:0] r, hi, lo;
    r  = (v + (64'sd1 <<< (sh - 1))) >>> sh;
    hi = (64'sd1 <<< (ow - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (ow - 1));
    if (r > hi) r = hi;
    else if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco import ddc_pkg::*; #(
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 first,
  input  logic [PW-1:0]        freq,
  output logic signed [TW-1:0] cos_o,
  output logic signed [TW-1:0] sin_o
);
  logic [PW-1:0] acc, used;
  logic [5:0]    p6;

  assign used = first ? '0 : acc;
  assign p6   = used[PW-1 -: 6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      cos_o <= '0;
      sin_o <= '0;
    end else if (take) begin
      acc   <= used + freq;
      cos_o <= qsin(p6 + 6'd16);
      sin_o <= qsin(p6);
    end
  end

  // R3: a buffer start restarts the phase, so the next phase is one step
  p_phase_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && first |=> acc == $past(freq));

endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer import ddc_pkg::*; #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 vin,
  input  logic                 fin,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [TW-1:0] c,
  input  logic signed [TW-1:0] s,
  output logic signed [DW-1:0] m_re,
  output logic signed [DW-1:0] m_im,
  output logic                 vo,
  output logic                 fo
);
  logic signed [63:0] sum_re, sum_im;

  assign sum_re = 64'(b_re) * 64'(c) - 64'(b_im) * 64'(s);
  assign sum_im = 64'(b_im) * 64'(c) + 64'(b_re) * 64'(s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vo   <= 1'b0;
      fo   <= 1'b0;
      m_re <= '0;
      m_im <= '0;
    end else if (adv) begin
      vo <= vin;
      fo <= vin && fin;
      if (vin) begin
        m_re <= DW'(rnd_sat(sum_re, TFRAC, DW));
        m_im <= DW'(rnd_sat(sum_im, TFRAC, DW));
      end
    end
  end

endmodule

// File: rtl/ddc_fir.sv
module ddc_fir import ddc_pkg::*; #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int NT = 4,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 vin,
  input  logic                 fin,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  logic                 cwe,
  input  logic [IW-1:0]        caddr,
  input  logic signed [CW-1:0] cval,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im,
  output logic                 vo,
  output logic                 fo
);
  localparam int ACCW = DW + CW + $clog2(NT) + 1;
  localparam int FRAC = CW - 1;

  logic signed [CW-1:0]   cf [0:NT-1];
  logic signed [DW-1:0]   xs [0:1];
  logic signed [DW-1:0]   yq [0:1];
  logic signed [ACCW-1:0] pr [0:1][0:NT-1];
  logic signed [ACCW-1:0] st [0:1][1:NT-1];
  logic signed [ACCW-1:0] nx [0:1][1:NT];

  assign xs[0] = x_re;
  assign xs[1] = x_im;
  assign y_re  = yq[0];
  assign y_im  = yq[1];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    for (genvar k = 0; k < NT; k++) begin : g_tap
      assign pr[l][k] = ACCW'(xs[l]) * ACCW'(cf[k]);
    end
  end

  // A buffer start replaces the partial sums by zero (zero padding)
  always_comb begin
    for (int l = 0; l < 2; l++) begin
      for (int k = 1; k < NT; k++) nx[l][k] = fin ? '0 : st[l][k];
      nx[l][NT] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin
        yq[l] <= '0;
        for (int k = 1; k < NT; k++) st[l][k] <= '0;
      end
    end else if (adv && vin) begin
      for (int l = 0; l < 2; l++) begin
        yq[l] <= DW'(rnd_sat(64'(pr[l][0] + nx[l][1]), FRAC, DW));
        for (int k = 1; k < NT; k++) st[l][k] <= pr[l][k] + nx[l][k+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vo <= 1'b0;
      fo <= 1'b0;
    end else if (adv) begin
      vo <= vin;
      fo <= vin && fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) cf[k] <= '0;
    end else if (cwe) begin
      for (int k = 0; k < NT; k++)
        if (caddr == IW'(k)) cf[k] <= cval;
    end
  end

  // R5: a buffer-start output never leaves without a valid sample
  p_first_marks_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fo |-> vo);

endmodule

// File: rtl/ddc_decim.sv
module ddc_decim #(
  parameter int DECIM = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic vin,
  input  logic fin,
  output logic keep
);
  localparam int CNTW = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [CNTW-1:0] cnt;
  logic            step;

  assign step = adv && vin;
  assign keep = vin && (fin || cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (step) begin
      if (fin) cnt <= (DECIM > 1) ? CNTW'(1) : '0;
      else if (cnt == CNTW'(DECIM - 1)) cnt <= '0;
      else cnt <= CNTW'(cnt + 1'b1);
    end
  end

  // R6: the first sample of a buffer is always kept
  p_first_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vin && fin |-> keep);

  // R6: the phase counter stays inside the decimation window
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < DECIM);

endmodule

// File: rtl/iq_ddc.sv
module iq_ddc import ddc_pkg::*; #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int PW    = 16,
  parameter int NT1   = 4,
  parameter int NT2   = 4,
  parameter int DECIM = 3,
  parameter int IW    = $clog2((NT1 > NT2) ? NT1 : NT2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        freq_word,
  input  logic                 coef_we,
  input  logic                 coef_bank,
  input  logic [IW-1:0]        coef_idx,
  input  logic signed [CW-1:0] coef_val,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_first,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_first,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  logic                 adv, take;
  logic                 s1_vld, s1_first;
  logic signed [DW-1:0] s1_re, s1_im;
  logic signed [TW-1:0] lo_cos, lo_sin;
  logic                 mx_vld, mx_first;
  logic signed [DW-1:0] mx_re, mx_im;
  logic                 f1_vld, f1_first, f1_keep;
  logic signed [DW-1:0] f1_re, f1_im;

  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;
  assign take     = adv && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_re    <= '0;
      s1_im    <= '0;
    end else if (adv) begin
      s1_vld   <= in_valid;
      s1_first <= in_valid && in_first;
      if (in_valid) begin
        s1_re <= in_re;
        s1_im <= in_im;
      end
    end
  end

  ddc_nco #(.PW(PW)) u_nco (
    .clk(clk), .rst_n(rst_n), .take(take), .first(in_first),
    .freq(freq_word), .cos_o(lo_cos), .sin_o(lo_sin)
  );

  ddc_mixer #(.DW(DW)) u_mix (
    .clk(clk), .rst_n(rst_n), .adv(adv), .vin(s1_vld), .fin(s1_first),
    .b_re(s1_re), .b_im(s1_im), .c(lo_cos), .s(lo_sin),
    .m_re(mx_re), .m_im(mx_im), .vo(mx_vld), .fo(mx_first)
  );

  ddc_fir #(.DW(DW), .CW(CW), .NT(NT1), .IW(IW)) u_fir1 (
    .clk(clk), .rst_n(rst_n), .adv(adv), .vin(mx_vld), .fin(mx_first),
    .x_re(mx_re), .x_im(mx_im),
    .cwe(coef_we && !coef_bank), .caddr(coef_idx), .cval(coef_val),
    .y_re(f1_re), .y_im(f1_im), .vo(f1_vld), .fo(f1_first)
  );

  ddc_decim #(.DECIM(DECIM)) u_dec (
    .clk(clk), .rst_n(rst_n), .adv(adv), .vin(f1_vld), .fin(f1_first),
    .keep(f1_keep)
  );

  ddc_fir #(.DW(DW), .CW(CW), .NT(NT2), .IW(IW)) u_fir2 (
    .clk(clk), .rst_n(rst_n), .adv(adv), .vin(f1_keep), .fin(f1_first),
    .x_re(f1_re), .x_im(f1_im),
    .cwe(coef_we && coef_bank), .caddr(coef_idx), .cval(coef_val),
    .y_re(out_re), .y_im(out_im), .vo(out_valid), .fo(out_first)
  );

  // R10: a stalled output keeps its value and blocks new input
  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im));

  p_stall_blocks_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: tb/iq_ddc_tb_top.sv
`timescale 1ns/1ps
module iq_ddc_tb_top;
  localparam real CLK = 20.0;
  localparam real TOL = 12.0;
  localparam int  D   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] freq_word = '0;
  logic coef_we = 1'b0, coef_bank = 1'b0;
  logic [1:0] coef_idx = '0;
  logic signed [15:0] coef_val = '0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_first;
  logic out_ready = 1'b1;
  logic signed [15:0] out_re, out_im;

  int total = 0, fails = 0;
  bit done = 0, bp_on = 0;
  logic [7:0] lf = 8'hA5;
  int got_n = 0, got_re[64], got_im[64];
  int stall_seen = 0, stall_bad = 0;
  bit prev_stall = 0;
  int prev_re = 0, prev_im = 0;
  int xr[64], xi[64], a1[4], a2[4];
  real exp_re[64], exp_im[64];
  int ne = 0;

  iq_ddc dut_i (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .coef_we(coef_we),
    .coef_bank(coef_bank), .coef_idx(coef_idx), .coef_val(coef_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_first(out_first), .out_re(out_re), .out_im(out_im)
  );

  always #(CLK/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    out_ready = bp_on ? lf[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (prev_stall && (!out_valid || out_re != prev_re || out_im != prev_im))
      stall_bad++;
    prev_stall = out_valid && !out_ready;
    prev_re = out_re;
    prev_im = out_im;
    if (prev_stall) begin
      stall_seen++;
      if (in_ready) stall_bad++;
    end
    if (out_valid && out_ready) begin
      if (got_n < 64) begin
        got_re[got_n] = out_re;
        got_im[got_n] = out_im;
      end
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic real clip(input real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  task automatic load(input bit bank, input int c0, c1, c2, c3);
    int c[4];
    c = '{c0, c1, c2, c3};
    for (int k = 0; k < 4; k++) begin
      coef_we = 1'b1; coef_bank = bank; coef_idx = 2'(k); coef_val = 16'(c[k]);
      if (bank) a2[k] = c[k]; else a1[k] = c[k];
      @(posedge clk); #1;
    end
    coef_we = 1'b0;
  endtask

  // Expected stream, computed in real arithmetic from the requirements
  task automatic model(input int L, input int nb, input int F);
    real mr[64], mi[64], zr[64], zi[64];
    ne = 0;
    for (int b = 0; b < nb; b++) begin
      int nk = 0;
      for (int n = 0; n < L; n++) begin
        int ph = (n * F) % 65536;
        real th = 2.0 * 3.14159265358979 * real'(ph >> 10) / 64.0;
        mr[n] = clip(xr[b*L+n] * $cos(th) - xi[b*L+n] * $sin(th));
        mi[n] = clip(xi[b*L+n] * $cos(th) + xr[b*L+n] * $sin(th));
      end
      for (int n = 0; n < L; n++) begin
        real yr = 0.0, yi = 0.0;
        for (int k = 0; k < 4; k++)
          if (n - k >= 0) begin
            yr += a1[k] / 32768.0 * mr[n-k];
            yi += a1[k] / 32768.0 * mi[n-k];
          end
        if (n % D == 0) begin
          zr[nk] = clip(yr); zi[nk] = clip(yi); nk++;
        end
      end
      for (int j = 0; j < nk; j++) begin
        real yr = 0.0, yi = 0.0;
        for (int k = 0; k < 4; k++)
          if (j - k >= 0) begin
            yr += a2[k] / 32768.0 * zr[j-k];
            yi += a2[k] / 32768.0 * zi[j-k];
          end
        exp_re[ne] = clip(yr); exp_im[ne] = clip(yi); ne++;
      end
    end
  endtask

  task automatic send(input int re, input int im, input bit first);
    in_valid = 1'b1; in_re = 16'(re); in_im = 16'(im); in_first = first;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic run_case(input string req, input int L, input int nb, input int F);
    freq_word = 16'(F);
    model(L, nb, F);
    got_n = 0;
    for (int i = 0; i < L * nb; i++) send(xr[i], xi[i], (i % L) == 0);
    repeat (80) @(posedge clk);
    #1;
    chk(got_n == ne, req, "output count", got_n, ne);
    for (int j = 0; j < ne && j < got_n; j++) begin
      chk((real'(got_re[j]) - exp_re[j]) <= TOL && (exp_re[j] - real'(got_re[j])) <= TOL,
          req, $sformatf("out[%0d] re", j), got_re[j], int'(exp_re[j]));
      chk((real'(got_im[j]) - exp_im[j]) <= TOL && (exp_im[j] - real'(got_im[j])) <= TOL,
          req, $sformatf("out[%0d] im", j), got_im[j], int'(exp_im[j]));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;
  endtask

  // R9 latency, R11 bank writes
  task automatic t_latency;
    int seen = 0;
    load(0, 32767, 0, 0, 0);
    load(1, 32767, 0, 0, 0);
    freq_word = '0;
    got_n = 0;
    send(9000, -4000, 1'b1);
    for (int w = 1; w <= 5; w++) begin
      @(negedge clk);
      if (out_valid && seen == 0) seen = w;
    end
    chk(seen == 4, "R9", "negedge of first out_valid", seen, 4);
    @(posedge clk); #1;
    repeat (10) @(posedge clk);
    #1;
    chk(got_n == 1 && got_re[0] > 8990 && got_re[0] < 9010, "R11", "identity banks re",
        got_re[0], 9000);
  endtask

  task automatic t_impulse;   // R4 shared taps, R11 tap indexing
    load(0, 16384, 8192, -4096, 2048);
    load(1, 32767, 0, 0, 0);
    for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 20000; xi[0] = -10000;
    run_case("R4", 8, 1, 0);
  endtask

  task automatic t_mixer;     // R2 and R3 with a nonzero step
    load(0, 32767, 0, 0, 0);
    load(1, 32767, 0, 0, 0);
    for (int n = 0; n < 12; n++) begin xr[n] = 12000; xi[n] = 5000; end
    run_case("R2", 12, 1, 5120);
  endtask

  task automatic t_decim;     // R6 which samples survive
    load(0, 32767, 0, 0, 0);
    load(1, 32767, 0, 0, 0);
    for (int n = 0; n < 10; n++) begin xr[n] = n * 1000; xi[n] = -n * 500; end
    run_case("R6", 10, 1, 0);
  endtask

  task automatic t_second;    // R7 second filter acts on kept samples
    load(0, 32767, 0, 0, 0);
    load(1, 8192, 8192, 8192, 8192);
    for (int n = 0; n < 12; n++) begin xr[n] = n * 1500; xi[n] = 3000 - n * 700; end
    run_case("R7", 12, 1, 0);
  endtask

  task automatic t_boundary;  // R5 padding, R6 restart, R3 phase restart
    load(0, 16384, 16384, 16384, 16384);
    load(1, 32767, 0, 0, 0);
    for (int n = 0; n < 10; n++) begin
      xr[n] = (n < 5) ? 8000 : -6000;
      xi[n] = (n < 5) ? 2000 : 7000;
    end
    run_case("R5", 5, 2, 3072);
  endtask

  task automatic t_saturate;  // R8 clipping at both rails
    load(0, 32767, 32767, 32767, 32767);
    load(1, 32767, 32767, 32767, 32767);
    for (int n = 0; n < 12; n++) begin xr[n] = 30000; xi[n] = -30000; end
    run_case("R8", 12, 1, 0);
    chk(got_re[3] == 32767, "R8", "upper rail", got_re[3], 32767);
    chk(got_im[3] == -32768, "R8", "lower rail", got_im[3], -32768);
  endtask

  task automatic t_backpressure;  // R10
    load(0, 16384, 8192, -4096, 2048);
    load(1, 16384, -8192, 8192, 4096);
    for (int n = 0; n < 24; n++) begin xr[n] = 9000 - n * 300; xi[n] = n * 450 - 4000; end
    stall_seen = 0; stall_bad = 0;
    @(negedge clk); bp_on = 1'b1;
    @(posedge clk); #1;
    run_case("R10", 12, 2, 5120);
    @(negedge clk); bp_on = 1'b0;
    @(posedge clk); #1;
    chk(stall_seen > 0, "R10", "stall cycles observed", stall_seen, 1);
    chk(stall_bad == 0, "R10", "hold or input block violations", stall_bad, 0);
  endtask

  initial begin
    #(CLK * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not complete (all requirements), actual 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_latency();
    t_impulse();
    t_mixer();
    t_decim();
    t_second();
    t_boundary();
    t_saturate();
    t_backpressure();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule